// File: doc/BRIEF.md
# UART Receive Character Queue

This block sits between the receive shifter of a UART and the CPU register interface. Each time the shifter finishes a character it presents the eight data bits and three error indications: break, framing and parity. The block queues the character together with those flags and a fourth flag, overrun, which the block raises itself. The CPU sees a status byte and a hold-data byte. The status byte carries a ready bit and the flags of the oldest queued character. A hold read removes that character, so the CPU reads the flags first and the data second.

A two-bit command input turns reception on and off. The disable and reset commands act in the cycle they are given. Both throw away a character whose start bit has been seen but whose data has not yet arrived. Reset also drops everything queued, while disable leaves the queue readable. After either command, reception stays off until an enable command arrives. A registered warning output tells flow-control logic that a start bit has arrived while the queue has at most one free slot left.

Top module: `rxq_top`

## Requirements
- R1: status[0] (ready) is 1 exactly when the queue holds at least one character.
- R2: When ready is 1, hold_data shows the oldest character's data, and a cycle with hold_rd high removes that character. A hold read while ready is 0 changes no state.
- R3: status[7:4] show the oldest character's flags in the order break, framing, parity, overrun (bit 7 down to bit 4), and read 0 when the queue is empty. status[3] is always 0.
- R4: A disable or reset command given between a start bit and its rx_valid pulse discards that character. This also holds when the command falls in the same cycle as rx_valid. Only characters whose start bit was accepted while enabled are queued.
- R5: A reset command empties the queue at once. A disable command keeps the queue, and hold reads continue to pop entries.
- R6: After reset, a disable command or a reset command, reception is off (status[2] = 0) and rx_valid pulses are ignored until an enable command.
- R7: The queue holds four characters. status[1] is 1 exactly when all four slots are in use.
- R8: A character that arrives while the queue is full and no pop happens in the same cycle is dropped, and the overrun flag of the newest stored character is set.
- R9: When the queue is full, a hold read and an incoming character in the same cycle both succeed and no overrun is flagged.
- R10: full_warn rises one cycle after an accepted start bit if at least three characters will be stored after that cycle. It falls once fewer than three are stored.
- R11: Command encoding: 0 = no operation, 1 = enable, 2 = disable, 3 = reset. status[2] shows whether reception is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_start | input | 1 | Start bit detected by the shifter |
| rx_valid | input | 1 | Assembled character available this cycle |
| rx_data | input | 8 | Character data |
| rx_err | input | 3 | {break, framing, parity} for the character |
| cmd | input | 2 | Receiver command (R11) |
| hold_rd | input | 1 | Hold-register read strobe; pops the oldest character |
| status | output | 8 | {flags[3:0], 0, enabled, full, ready} |
| hold_data | output | 8 | Data of the oldest character |
| full_warn | output | 1 | Queue about to fill, for flow control |

## Verification
The collision that matters is a hold read and a character arrival in the same cycle. On a full queue, the order of the two decides whether the new character is kept or flagged as an overrun. The bench fills the queue, raises a start bit, and then pulses rx_valid and hold_rd together. A queue-based reference model, compared every clock, shows the new character at the tail with no overrun flag. A second collision places a disable or reset command in the same cycle as rx_valid, and the character must be lost in both cases. After a disable, the queue contents must remain readable.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        CMD_NOP     = 2'd0,
        CMD_ENABLE  = 2'd1,
        CMD_DISABLE = 2'd2,
        CMD_RESET   = 2'd3
    } rx_cmd_e;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
        logic ovr;
    } rx_flags_t;

    typedef struct packed {
        rx_flags_t         flg;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef struct packed {
        rx_flags_t flg;
        logic      spare;
        logic      enabled;
        logic      full;
        logic      ready;
    } rx_status_t;

    function automatic rx_flags_t flags_from_err(input logic [2:0] err);
        rx_flags_t f;
        f.brk = err[2];
        f.frm = err[1];
        f.par = err[0];
        f.ovr = 1'b0;
        return f;
    endfunction

    function automatic logic cmd_stops(input rx_cmd_e c);
        return (c == CMD_DISABLE) || (c == CMD_RESET);
    endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  rx_cmd_e cmd,
    input  logic    rx_start,
    input  logic    rx_valid,
    output logic    rx_on,
    output logic    flush,
    output logic    start_ok,
    output logic    push
);
    logic busy;
    logic stop;

    always_comb begin
        stop     = cmd_stops(cmd);
        flush    = (cmd == CMD_RESET);
        start_ok = rx_on && rx_start && !stop;
        push     = rx_on && busy && rx_valid && !stop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_on <= 1'b0;
            busy  <= 1'b0;
        end else begin
            if (cmd == CMD_ENABLE)
                rx_on <= 1'b1;
            else if (stop)
                rx_on <= 1'b0;

            if (stop)
                busy <= 1'b0;
            else if (start_ok)
                busy <= 1'b1;
            else if (rx_valid)
                busy <= 1'b0;
        end
    end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic             pop_req,
    input  rx_entry_t        wr_entry,
    output rx_entry_t        head,
    output logic [CNT_W-1:0] fill,
    output logic [CNT_W-1:0] fill_nxt
);
    rx_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] wp, rp, last_ptr;
    logic             pop, room, push_ok, drop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        pop      = pop_req && (fill != '0) && !flush;
        room     = (fill < CNT_W'(DEPTH)) || pop;
        push_ok  = push && !flush && room;
        drop     = push && !flush && !room;
        last_ptr = (wp == '0) ? PTR_W'(DEPTH - 1) : wp - PTR_W'(1);
        fill_nxt = flush ? '0 : fill + CNT_W'(push_ok) - CNT_W'(pop);
        head     = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (push_ok) wp <= ptr_inc(wp);
            if (pop)     rp <= ptr_inc(rp);
            fill <= fill_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst) begin
            if (push_ok)
                mem[wp] <= wr_entry;
            else if (drop)
                mem[last_ptr].flg.ovr <= 1'b1;
        end
    end
endmodule

// File: rtl/rxq_warn.sv
module rxq_warn #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_ok,
    input  logic [CNT_W-1:0] fill_nxt,
    output logic             full_warn
);
    localparam logic [CNT_W-1:0] THRESH = CNT_W'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst)
            full_warn <= 1'b0;
        else if (fill_nxt < THRESH)
            full_warn <= 1'b0;
        else if (start_ok)
            full_warn <= 1'b1;
    end
endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_start,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic [2:0]  rx_err,
    input  logic [1:0]  cmd,
    input  logic        hold_rd,
    output logic [7:0]  status,
    output logic [7:0]  hold_data,
    output logic        full_warn
);
    rx_cmd_e          cmd_e;
    logic             rx_on, flush, start_ok, push;
    rx_entry_t        wr_entry, head;
    logic [CNT_W-1:0] fill, fill_nxt;
    rx_status_t       st;

    assign cmd_e = rx_cmd_e'(cmd);

    always_comb begin
        wr_entry.flg  = flags_from_err(rx_err);
        wr_entry.data = rx_data;
    end

    rxq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd_e),
        .rx_start (rx_start),
        .rx_valid (rx_valid),
        .rx_on    (rx_on),
        .flush    (flush),
        .start_ok (start_ok),
        .push     (push)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .push     (push),
        .pop_req  (hold_rd),
        .wr_entry (wr_entry),
        .head     (head),
        .fill     (fill),
        .fill_nxt (fill_nxt)
    );

    rxq_warn #(.DEPTH(DEPTH)) u_warn (
        .clk       (clk),
        .rst       (rst),
        .start_ok  (start_ok),
        .fill_nxt  (fill_nxt),
        .full_warn (full_warn)
    );

    always_comb begin
        st.ready   = (fill != '0);
        st.full    = (fill == CNT_W'(DEPTH));
        st.enabled = rx_on;
        st.spare   = 1'b0;
        st.flg     = st.ready ? head.flg : '0;
        status     = st;
        hold_data  = st.ready ? head.data : '0;
    end
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       cmd,
    input logic             hold_rd,
    input logic             rx_start,
    input logic [7:0]       status,
    input logic             full_warn,
    input logic [CNT_W-1:0] fill
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(DEPTH)); // R7

    AST_RESET_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        cmd == 2'd3 |=> !status[0]); // R5

    AST_DISABLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (cmd == 2'd2 && status[0] && !hold_rd) |=> status[0]); // R5

    AST_STAY_OFF: assert property (@(posedge clk) disable iff (rst)
        (!status[2] && cmd != 2'd1) |=> !status[2]); // R6

    AST_POP_ONE: assert property (@(posedge clk) disable iff (rst)
        (cmd == 2'd2 && status[0] && hold_rd) |=> fill == $past(fill) - CNT_W'(1)); // R2

    AST_EMPTY_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
        !status[0] |-> status[7:3] == 5'd0); // R3

    AST_WARN_SET: assert property (@(posedge clk) disable iff (rst)
        (rx_start && status[2] && cmd == 2'd0 && !hold_rd && fill == CNT_W'(DEPTH - 1))
        |=> full_warn); // R10
endmodule

bind rxq_top rxq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .hold_rd   (hold_rd),
    .rx_start  (rx_start),
    .status    (status),
    .full_warn (full_warn),
    .fill      (fill)
);

// File: tb/sim_rxq_top.sv
module sim_rxq_top;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst, rx_start, rx_valid, hold_rd;
    logic [7:0] rx_data;
    logic [2:0] rx_err;
    logic [1:0] cmd;
    logic [7:0] status, hold_data;
    logic       full_warn;

    int n_chk  = 0;
    int n_fail = 0;

    logic [11:0] q[$];
    bit m_on, m_prog, m_fw;

    rxq_top u0 (
        .clk(clk), .rst(rst), .rx_start(rx_start), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_err(rx_err), .cmd(cmd), .hold_rd(hold_rd),
        .status(status), .hold_data(hold_data), .full_warn(full_warn)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic model(input bit st, input bit cv, input logic [7:0] d,
                         input logic [2:0] e, input logic [1:0] c, input bit rd);
        bit stop, start_ok, acc;
        stop     = (c == 2'd2) || (c == 2'd3);
        start_ok = m_on && st && !stop;
        acc      = m_on && m_prog && cv && !stop;
        if (c == 2'd3) begin
            q.delete();
        end else begin
            if (rd && q.size() > 0) void'(q.pop_front());
            if (acc) begin
                if (q.size() < 4) q.push_back({e, 1'b0, d});
                else q[q.size()-1][8] = 1'b1;
            end
        end
        if (q.size() < 3) m_fw = 0;
        else if (start_ok) m_fw = 1;
        if (stop) m_prog = 0;
        else if (start_ok) m_prog = 1;
        else if (cv) m_prog = 0;
        if (c == 2'd1) m_on = 1;
        else if (stop) m_on = 0;
    endtask

    task automatic compare();
        bit rdy;
        rdy = q.size() > 0;
        chk("R1 ready", status[0], rdy);
        chk("R7 full", status[1], q.size() == 4);
        chk("R11 enabled", status[2], m_on);
        chk("R3 spare", status[3], 1'b0);
        chk("R3 flags", status[7:4], rdy ? q[0][11:8] : 4'h0);
        if (rdy) chk("R2 hold data", hold_data, q[0][7:0]);
        chk("R10 warn", full_warn, m_fw);
    endtask

    task automatic step(input bit st, input bit cv, input logic [7:0] d,
                        input logic [2:0] e, input logic [1:0] c, input bit rd);
        @(negedge clk);
        rx_start = st; rx_valid = cv; rx_data = d; rx_err = e; cmd = c; hold_rd = rd;
        model(st, cv, d, e, c, rd);
        @(posedge clk);
        #1;
        compare();
    endtask

    task automatic idle(); step(0, 0, 8'h00, 3'd0, 2'd0, 0); endtask
    task automatic command(input logic [1:0] c); step(0, 0, 8'h00, 3'd0, c, 0); endtask
    task automatic rd(); step(0, 0, 8'h00, 3'd0, 2'd0, 1); endtask
    task automatic rx_char(input logic [7:0] d, input logic [2:0] e);
        step(1, 0, 8'h00, 3'd0, 2'd0, 0);
        idle();
        step(0, 1, d, e, 2'd0, 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1; rx_start = 0; rx_valid = 0; rx_data = 0; rx_err = 0; cmd = 0; hold_rd = 0;
        m_on = 0; m_prog = 0; m_fw = 0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 reset status", status, 8'h00);
        chk("R10 reset warn", full_warn, 1'b0);
        @(negedge clk); rst = 0;

        // R6: off after reset, characters ignored
        rx_char(8'h11, 3'd0);
        chk("R6 ignored while off", status[0], 1'b0);

        command(2'd1);
        chk("R11 enable", status[2], 1'b1);

        // R2 / R3: flags readable before pop
        rx_char(8'hA5, 3'b001);
        chk("R3 parity flag", status[5], 1'b1);
        chk("R2 head data", hold_data, 8'hA5);
        rd();
        chk("R2 popped", status[0], 1'b0);
        rd(); // R2 empty read: no state change
        chk("R2 empty read", status, 8'h04);

        // R7 / R10 / R8: fill to capacity then overflow
        rx_char(8'h01, 3'b100);
        rx_char(8'h02, 3'b010);
        rx_char(8'h03, 3'b000);
        step(1, 0, 8'h00, 3'd0, 2'd0, 0);
        chk("R10 warn on start with one slot", full_warn, 1'b1);
        idle();
        step(0, 1, 8'h04, 3'd0, 2'd0, 0);
        chk("R7 full", status[1], 1'b1);
        rx_char(8'h05, 3'd0);
        chk("R8 still four", status[1], 1'b1);
        chk("R3 break flag head", status[7], 1'b1);

        // R9: pop and push together on a full queue
        step(1, 0, 8'h00, 3'd0, 2'd0, 0);
        idle();
        step(0, 1, 8'h06, 3'd0, 2'd0, 1);
        chk("R9 still full", status[1], 1'b1);
        rd(); rd();
        chk("R8 overrun on newest", status[4], 1'b1);
        chk("R8 newest data", hold_data, 8'h04);
        rd();
        chk("R9 tail kept no overrun", {status[4], hold_data}, {1'b0, 8'h06});
        chk("R10 warn cleared", full_warn, 1'b0);

        // R4 / R5: disable mid-character, queue stays readable
        rx_char(8'h21, 3'd0);
        step(1, 0, 8'h00, 3'd0, 2'd0, 0);
        command(2'd2);
        step(0, 1, 8'h22, 3'd0, 2'd0, 0);
        chk("R4 partial discarded", hold_data, 8'h06);
        rd();
        chk("R5 disable keeps", hold_data, 8'h21);
        rx_char(8'h23, 3'd0);
        command(2'd1);
        // R4: disable in same cycle as rx_valid
        step(1, 0, 8'h00, 3'd0, 2'd0, 0);
        step(0, 1, 8'h24, 3'd0, 2'd2, 0);
        rd();
        rd();
        chk("R4 same-cycle disable", status[0], 1'b0);

        // R5: reset empties; R4 reset mid-character
        command(2'd1);
        rx_char(8'h31, 3'b011);
        rx_char(8'h32, 3'd0);
        step(1, 0, 8'h00, 3'd0, 2'd0, 0);
        command(2'd3);
        chk("R5 reset empties", status, 8'h00);
        step(0, 1, 8'h33, 3'd0, 2'd1, 0);
        chk("R4 reset discards partial", status[0], 1'b0);
        rx_char(8'h34, 3'd0);
        chk("R6 enable after reset", hold_data, 8'h34);
        repeat (3) idle();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule